// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block sits between a pipelined memory-mapped read port and a word memory that returns data a fixed number of cycles after each fetch. A host presents a start word, a beat count and a mode flag. The sequencer accepts the command, issues one fetch address per cycle and marks every returned word with a valid strobe. It also holds its wait signal high until the last beat of the burst has come back.

Two orderings are supported. An incrementing burst may start at any word and climbs one word per beat, for up to 128 beats. A wrapping burst has a fixed length equal to the wrap-group size, which is a parameter set to 2 or 4 to match the width of the internal fetch. It begins at the requested word, which may sit anywhere inside its aligned group. It runs to the top of that group and then continues from the group's first word until every word of the group has been delivered.

A command with an illegal beat count is answered with a single blank beat that carries the failure flag. Any beat whose word lies at or beyond the end of the populated memory also returns blank data with the failure flag set, and no memory fetch is made for it.

Top module: `burst_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `wait_o`, `rvalid_o`, `rfail_o` and `mem_en_o` are all 0.
- R2: An incrementing burst (`rd_wrap`=0) of N beats (1 to 128) starting at word A returns N beats on N consecutive cycles carrying words A, A+1, …, A+N-1. The start word need not be aligned. The first beat appears LAT+1 cycles after the cycle in which the command was accepted.
- R3: An incrementing command with `rd_len` equal to 0 or greater than 128 returns exactly one beat, with `rfail_o`=1 and `rdata_o` all ones.
- R4: A wrapping burst (`rd_wrap`=1) with `rd_len` equal to WRAP_N returns WRAP_N beats. For a start word at offset o in its aligned group with base B, beat k carries word B + ((o+k) mod WRAP_N). With WRAP_N=4 and start word 6, the beats carry words 6, 7, 4, 5.
- R5: A wrapping command whose `rd_len` differs from WRAP_N returns exactly one beat, with `rfail_o`=1 and `rdata_o` all ones.
- R6: Every beat whose word is at or above NUM_WORDS still counts as a beat, but returns `rdata_o` all ones with `rfail_o`=1. Beats of the same burst below that limit are unaffected.
- R7: A command is taken only when `rd_req`=1 and `wait_o`=0. `wait_o` rises the cycle after acceptance and stays high through the cycle of the last beat. It falls in the cycle after that. A request made while `wait_o`=1 has no effect on the beats.
- R8: A beat at a legal in-range word has `rfail_o`=0 and `rdata_o` equal to the memory word at that address.
- R9: `mem_en_o` is raised once for each in-range beat of a legal command, with `mem_addr_o` set to that beat's word. It is never raised for a failing beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read command strobe |
| rd_addr | input | AW | Start word of the burst |
| rd_len | input | LENW | Beat count |
| rd_wrap | input | 1 | 1 = wrapping burst, 0 = incrementing burst |
| wait_o | output | 1 | Busy; commands are ignored while high |
| rvalid_o | output | 1 | One pulse per returned beat |
| rdata_o | output | 32 | Beat data, all ones when the beat fails |
| rfail_o | output | 1 | Read failure flag for the current beat |
| mem_en_o | output | 1 | Memory fetch enable |
| mem_addr_o | output | AW | Memory fetch word address |
| mem_rdata_i | input | 32 | Memory word, LAT cycles after its fetch |

## Verification
The bench builds the block with AW=8, NUM_WORDS=200, WRAP_N=4 and LAT=2. Because the populated limit lies below the 256-word address space, an incrementing burst can cross the end of memory partway through. Starts near the top of the address space fail on every beat. A 4-word group allows all four start offsets to be tried, including the top word of a group, so the wrap-back point falls on every beat position. A latency of two puts two beats in flight when the wait signal drops, which exposes any early return to idle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DRAIN = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic valid;
        logic fail;
    } beat_tag_t;

    localparam logic [31:0] BLANK_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/burst_cmd_check.sv
module burst_cmd_check #(
    parameter int MAX_BURST = 128,
    parameter int WRAP_N    = 4,
    parameter int LENW      = 8
) (
    input  logic [LENW-1:0] len_i,
    input  logic            wrap_i,
    output logic            legal_o
);
    localparam logic [LENW-1:0] MAX_L  = LENW'(MAX_BURST);
    localparam logic [LENW-1:0] WRAP_L = LENW'(WRAP_N);

    logic inc_ok;
    logic wrp_ok;

    always_comb begin
        inc_ok  = (len_i != '0) && (len_i <= MAX_L);
        wrp_ok  = (len_i == WRAP_L);
        legal_o = wrap_i ? wrp_ok : inc_ok;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW     = 8,
    parameter int WRAP_N = 4
) (
    input  logic [AW:0] cur_i,
    input  logic        wrap_i,
    output logic [AW:0] nxt_o
);
    localparam int WB = $clog2(WRAP_N);

    logic [AW:0] inc_nxt;
    logic [AW:0] wrp_nxt;

    always_comb inc_nxt = cur_i + (AW+1)'(1);

    generate
        if (WB > 0) begin : g_group
            always_comb wrp_nxt = {cur_i[AW:WB], cur_i[WB-1:0] + WB'(1)};
        end else begin : g_single
            always_comb wrp_nxt = cur_i;
        end
    endgenerate

    always_comb nxt_o = wrap_i ? wrp_nxt : inc_nxt;

endmodule

// File: rtl/beat_tag_pipe.sv
module beat_tag_pipe
    import burst_seq_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  beat_tag_t tag_i,
    output beat_tag_t tag_o
);
    beat_tag_t stage_d [LAT];
    beat_tag_t stage_q [LAT];

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_comb stage_d[i] = tag_i;
            end else begin : g_body
                always_comb stage_d[i] = stage_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_d[i];
            end
        end
    endgenerate

    assign tag_o = stage_q[LAT-1];

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import burst_seq_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NUM_WORDS = 200,
    parameter int MAX_BURST = 128,
    parameter int WRAP_N    = 4,
    parameter int LAT       = 2,
    parameter int LENW      = $clog2(MAX_BURST) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    input  logic [LENW-1:0] rd_len,
    input  logic            rd_wrap,
    output logic            wait_o,
    output logic            rvalid_o,
    output logic [31:0]     rdata_o,
    output logic            rfail_o,
    output logic            mem_en_o,
    output logic [AW-1:0]   mem_addr_o,
    input  logic [31:0]     mem_rdata_i
);
    localparam int           WB    = $clog2(WRAP_N);
    localparam int           LATW  = $clog2(LAT + 1);
    localparam logic [AW:0]  LIMIT = (AW+1)'(NUM_WORDS);

    typedef struct packed {
        sq_state_e       st;
        logic [AW:0]     cur;
        logic [AW:0]     base;
        logic            wrap;
        logic            err;
        logic [LENW-1:0] left;
        logic [LATW-1:0] drn;
    } seq_s;

    seq_s q, d;

    logic        legal;
    logic        accept;
    logic        beat_fail;
    logic [AW:0] nxt_addr;
    beat_tag_t   tag_in;
    beat_tag_t   tag_out;

    burst_cmd_check #(
        .MAX_BURST (MAX_BURST),
        .WRAP_N    (WRAP_N),
        .LENW      (LENW)
    ) u_chk (
        .len_i   (rd_len),
        .wrap_i  (rd_wrap),
        .legal_o (legal)
    );

    burst_addr_gen #(
        .AW     (AW),
        .WRAP_N (WRAP_N)
    ) u_agen (
        .cur_i  (q.cur),
        .wrap_i (q.wrap),
        .nxt_o  (nxt_addr)
    );

    beat_tag_pipe #(
        .LAT (LAT)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .tag_i (tag_in),
        .tag_o (tag_out)
    );

    always_comb begin
        d         = q;
        accept    = (q.st == SQ_IDLE) && rd_req;
        beat_fail = q.err || (q.cur >= LIMIT);
        tag_in    = '0;

        case (q.st)
            SQ_IDLE: begin
                if (accept) begin
                    d.st   = SQ_ISSUE;
                    d.cur  = {1'b0, rd_addr};
                    d.base = {1'b0, rd_addr};
                    d.wrap = rd_wrap;
                    d.err  = !legal;
                    d.left = legal ? rd_len : LENW'(1);
                end
            end
            SQ_ISSUE: begin
                tag_in.valid = 1'b1;
                tag_in.fail  = beat_fail;
                d.cur        = nxt_addr;
                d.left       = q.left - LENW'(1);
                if (q.left == LENW'(1)) begin
                    d.st  = SQ_DRAIN;
                    d.drn = LATW'(LAT);
                end
            end
            SQ_DRAIN: begin
                d.drn = q.drn - LATW'(1);
                if (q.drn == LATW'(1)) begin
                    d.st = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        wait_o     = (q.st != SQ_IDLE);
        mem_en_o   = (q.st == SQ_ISSUE) && !beat_fail;
        mem_addr_o = q.cur[AW-1:0];
        rvalid_o   = tag_out.valid;
        rfail_o    = tag_out.valid && tag_out.fail;
        if (!tag_out.valid)    rdata_o = '0;
        else if (tag_out.fail) rdata_o = BLANK_WORD;
        else                   rdata_o = mem_rdata_i;
    end

    AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> wait_o); // R7

    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_o |-> !mem_en_o); // R9

    AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> ({1'b0, mem_addr_o} < LIMIT)); // R9

    AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_ISSUE && q.wrap) |-> (q.cur[AW:WB] == q.base[AW:WB])); // R4

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_ISSUE && !q.wrap && $past(q.st == SQ_ISSUE))
            |-> (q.cur == $past(q.cur) + (AW+1)'(1))); // R2

    AST_ERR_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_ISSUE && q.err) |-> (q.left == LENW'(1))); // R3

endmodule

// File: tb/sim_burst_rd_seq.sv
module sim_burst_rd_seq;
    localparam int AW   = 8;
    localparam int NW   = 200;
    localparam int MAXB = 128;
    localparam int WN   = 4;
    localparam int LAT  = 2;
    localparam int LENW = 8;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] n;
        logic       w;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   8'd1,   1'b0},
        '{8'd5,   8'd8,   1'b0},
        '{8'd37,  8'd7,   1'b0},
        '{8'd8,   8'd4,   1'b1},
        '{8'd6,   8'd4,   1'b1},
        '{8'd13,  8'd4,   1'b1},
        '{8'd15,  8'd4,   1'b1},
        '{8'd190, 8'd20,  1'b0},
        '{8'd0,   8'd128, 1'b0},
        '{8'd3,   8'd0,   1'b0},
        '{8'd3,   8'd129, 1'b0},
        '{8'd9,   8'd2,   1'b1},
        '{8'd198, 8'd4,   1'b1},
        '{8'd202, 8'd4,   1'b1},
        '{8'd250, 8'd3,   1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_req = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [LENW-1:0] rd_len = '0;
    logic            rd_wrap = 1'b0;
    logic            wait_o, rvalid_o, rfail_o, mem_en_o;
    logic [31:0]     rdata_o, mem_rdata;
    logic [AW-1:0]   mem_addr_o;
    logic [31:0]     mpipe [LAT];

    int n_run = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] memf(input int a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0001_0101);
    endfunction

    always @(posedge clk) begin
        mpipe[0] <= mem_en_o ? memf(int'(mem_addr_o)) : 32'hDEAD_BEEF;
        for (int k = 1; k < LAT; k++) mpipe[k] <= mpipe[k-1];
    end
    assign mem_rdata = mpipe[LAT-1];

    burst_rd_seq #(
        .AW (AW), .NUM_WORDS (NW), .MAX_BURST (MAXB),
        .WRAP_N (WN), .LAT (LAT), .LENW (LENW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_len (rd_len), .rd_wrap (rd_wrap), .wait_o (wait_o),
        .rvalid_o (rvalid_o), .rdata_o (rdata_o), .rfail_o (rfail_o),
        .mem_en_o (mem_en_o), .mem_addr_o (mem_addr_o), .mem_rdata_i (mem_rdata)
    );

    task automatic chk(input bit ok, input string tg, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
        end
    endtask

    function automatic int beat_addr(input int a, input int k, input bit w);
        int b;
        if (!w) return a + k;
        b = a - (a % WN);
        return b + ((a - b + k) % WN);
    endfunction

    task automatic run_burst(input int a, input int n, input bit w,
                             input string tg, input int poke);
        bit legal;
        int exp_beats, exp_fetch, got, fetch, cyc, ea;
        bit efail;
        logic [31:0] edat;
        legal = w ? (n == WN) : (n >= 1 && n <= MAXB);
        exp_beats = legal ? n : 1;
        exp_fetch = 0;
        for (int k = 0; k < exp_beats; k++)
            if (legal && beat_addr(a, k, w) < NW) exp_fetch++;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a); rd_len = LENW'(n); rd_wrap = w;
        @(negedge clk);
        rd_req = 1'b0;
        cyc = 1; got = 0; fetch = 0;
        while (cyc < 400) begin
            if (poke != 0 && cyc == poke) begin
                rd_req = 1'b1; rd_addr = 8'd100; rd_len = 8'd3; rd_wrap = 1'b0;
            end else begin
                rd_req = 1'b0;
            end
            if (mem_en_o) fetch++;
            if (rvalid_o) begin
                ea    = beat_addr(a, got, w);
                efail = !legal || ea >= NW;
                edat  = efail ? 32'hFFFF_FFFF : memf(ea);
                chk(cyc == LAT + 1 + got, tg, $sformatf("beat %0d cycle", got), cyc, LAT + 1 + got);
                chk(rfail_o == efail, tg, $sformatf("beat %0d fail flag", got), rfail_o, efail);
                chk(rdata_o == edat, tg, $sformatf("beat %0d data", got), rdata_o, edat);
                got++;
            end
            if (!wait_o) break;
            @(negedge clk);
            cyc++;
        end
        rd_req = 1'b0;
        chk(got == exp_beats, tg, "beat count", got, exp_beats);
        chk(cyc == LAT + exp_beats + 1, "R7", "wait release cycle", cyc, LAT + exp_beats + 1);
        chk(fetch == exp_fetch, "R9", "fetch count", fetch, exp_fetch);
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.w && int'(v.n) != WN) return "R5";
        if (!v.w && (v.n == 0 || int'(v.n) > MAXB)) return "R3";
        if (int'(v.a) + (v.w ? 0 : int'(v.n) - 1) >= NW || int'(v.a) >= NW) return "R6";
        if (v.w) return "R4";
        return "R2";
    endfunction

    initial begin
        #(10 * 150000);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!wait_o && !rvalid_o && !rfail_o && !mem_en_o, "R1", "reset outputs",
            {wait_o, rvalid_o, rfail_o, mem_en_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wait_o && !rvalid_o && !mem_en_o, "R1", "outputs after reset",
            {wait_o, rvalid_o, mem_en_o}, 0);

        for (int i = 0; i < NV; i++)
            run_burst(int'(VECS[i].a), int'(VECS[i].n), VECS[i].w, tag_of(VECS[i]), 0);

        // R7: request while busy is ignored
        run_burst(20, 6, 1'b0, "R7", 2);
        for (int k = 0; k < 6; k++) begin
            chk(!rvalid_o && !wait_o, "R7", "no beats after ignored request",
                {rvalid_o, wait_o}, 0);
            @(negedge clk);
        end

        // R8: back-to-back legal bursts return memory words
        run_burst(100, 5, 1'b0, "R8", 0);
        run_burst(101, 4, 1'b1, "R8", 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule